// File: doc/BRIEF.md
# Remote Terminal Reply Checker

This block judges the reply that a remote terminal gives to a message sent by the bus controller on a dual-redundant serial command/response bus. At the start of each message the controller loads the block's expectations: the address of the responding terminal, the number of data words that should come back, whether the message is a terminal-to-terminal transfer (and if so, the address of the transmitting terminal), and a 2-bit selection of the no-response timeout. When the controller finishes transmitting, it pulses `tx_end` and the block arms a response timer.

From then on the block consumes decoded word events from a Manchester decoder. Each event carries the sync type, the terminal address field of the word, and the decoder's encoding, parity and bit-count error flags. The block walks through the expected reply layout (status word, data words and, for terminal-to-terminal transfers, a second status word), accumulating sticky error bits. The timer restarts at the end of every reply word. The message ends when the timer runs out, and `done` then holds the verdict until the next message starts.

Timing comes from a microsecond tick that is divided down from the system clock. The divider is restarted together with the timer, so every timeout is an exact number of clock cycles.

Top module: `rt_reply_checker`

## Requirements
- R1: `cfg_to_sel` picks the timeout: 0 selects 18 us, 1 selects 22 us, 2 selects 50 us and 3 selects 130 us, with 1 us = CLKS_PER_US clocks. The timer starts on `tx_end` and restarts on every reply word. If it expires while a status word is awaited, error bit 0 (timeout) is set, and `done` rises limit*CLKS_PER_US+1 clocks after the edge that sampled `tx_end`.
- R2: A status-word position needs `word_cmd_sync`=1 and a data-word position needs `word_cmd_sync`=0. A mismatch sets bit 1 (sync), and the word still fills its position.
- R3: On any reply word accepted between `tx_end` and `done`, `word_enc_err`, `word_par_err` and `word_bit_err` set bit 2 (encoding), bit 3 (parity) and bit 4 (bit count) respectively.
- R4: The timer expiring before all `cfg_word_cnt` data words have arrived sets bit 5 (word count) and ends the message. So does any data word beyond the count, and so does any word after the final status word.
- R5: On a status word with correct sync, `word_rt_addr` (bits 15:11 of the word) must equal the expected address, otherwise bit 6 (address) is set. The address is not compared when the sync is wrong.
- R6: With `cfg_rt2rt`=1, the first status word is compared with `cfg_tx_addr`, then the data words are taken, then a second status word is compared with `cfg_rt_addr`. A timeout while either status word is awaited sets bit 0.
- R7: After the final expected word, the message ends when the timer expires with no further word. `done` stays high until the next `msg_start`, and `pass` is high exactly when `done` is high and all seven error bits are 0.
- R8: `msg_start` clears the error bits, drops `done` and captures the configuration. `busy` is high on the next cycle.
- R9: A word that arrives while `done` is high sets bit 0. It changes nothing else, and `done` stays high.
- R10: Words that arrive while idle, or after `msg_start` but before `tx_end`, have no effect.
- R11: After reset, `busy`, `done` and `pass` are 0 and all error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | Pulse: a new message begins; captures cfg_* |
| cfg_rt2rt | input | 1 | Message is a terminal-to-terminal transfer |
| cfg_rt_addr | input | 5 | Address of the terminal whose status closes the reply |
| cfg_tx_addr | input | 5 | Address of the transmitting terminal (rt2rt only) |
| cfg_word_cnt | input | 6 | Expected number of reply data words (0..32) |
| cfg_to_sel | input | 2 | Timeout select: 18/22/50/130 us |
| tx_end | input | 1 | Pulse: controller transmission finished |
| word_vld | input | 1 | Pulse: decoder delivered a word |
| word_cmd_sync | input | 1 | 1 = command/status sync, 0 = data sync |
| word_rt_addr | input | 5 | Bits 15:11 of the decoded word |
| word_enc_err | input | 1 | Manchester encoding error on the word |
| word_par_err | input | 1 | Parity error on the word |
| word_bit_err | input | 1 | Bit-count error on the word |
| busy | output | 1 | Message in progress (armed or listening) |
| done | output | 1 | Verdict available |
| pass | output | 1 | Done with no error bit set |
| err_flags | output | 7 | {address, word count, bit count, parity, encoding, sync, timeout} |

## Verification
The assertions assume that `msg_start`, `tx_end` and `word_vld` are single-cycle pulses, that `word_vld` never coincides with `msg_start`, and that `tx_end` arrives only while a message waits for it. Under these assumptions the error bits can only grow within a message, a late word always shows up as a timeout, and idle words leave the flags untouched. The stimulus drives every pulse for exactly one cycle at the falling edge and spaces words several cycles apart. It only places words on either side of a timeout boundary with a margin of several cycles, so it never relies on the tie between a word and an expiry in the same cycle.

// File: rtl/rt_reply_pkg.sv
package rt_reply_pkg;

    localparam int MAX_WORDS = 32;
    localparam int WC_W      = $clog2(MAX_WORDS + 1);
    localparam int ADDR_W    = 5;
    localparam int TMR_W     = 8;
    localparam int ERR_W     = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARMED,
        PH_STAT1,
        PH_DATA,
        PH_STAT2,
        PH_TAIL,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic addr_mis;
        logic wcnt;
        logic bitcnt;
        logic parity;
        logic enc;
        logic sync;
        logic tmo;
    } err_t;

    typedef struct packed {
        logic              rt2rt;
        logic [ADDR_W-1:0] rt_addr;
        logic [ADDR_W-1:0] tx_addr;
        logic [WC_W-1:0]   wcnt;
        logic [1:0]        to_sel;
    } cfg_t;

    function automatic logic [TMR_W-1:0] timeout_us(input logic [1:0] sel);
        case (sel)
            2'd0:    return TMR_W'(18);
            2'd1:    return TMR_W'(22);
            2'd2:    return TMR_W'(50);
            default: return TMR_W'(130);
        endcase
    endfunction

    function automatic err_t fold_word_flags(input err_t e, input logic enc,
                                             input logic par, input logic bits);
        err_t r;
        r        = e;
        r.enc    = e.enc | enc;
        r.parity = e.parity | par;
        r.bitcnt = e.bitcnt | bits;
        return r;
    endfunction

endpackage

// File: rtl/rt_us_tick.sv
module rt_us_tick #(
    parameter int CLKS_PER_US = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = $clog2(CLKS_PER_US + 1);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] pre;

    assign tick = (pre == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre <= '0;
        else if (tick)   pre <= '0;
        else             pre <= pre + PW'(1);
    end
endmodule

// File: rtl/rt_reply_timer.sv
module rt_reply_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    input  logic          arm,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] us_cnt;
    logic          run;

    assign expire = run && (us_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            run    <= 1'b0;
            us_cnt <= '0;
        end else if (arm) begin
            run    <= 1'b1;
            us_cnt <= '0;
        end else if (expire) begin
            run    <= 1'b0;
        end else if (run && tick) begin
            us_cnt <= us_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rt_reply_checker.sv
module rt_reply_checker
    import rt_reply_pkg::*;
#(
    parameter int CLKS_PER_US = 250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        msg_start,
    input  logic        cfg_rt2rt,
    input  logic [4:0]  cfg_rt_addr,
    input  logic [4:0]  cfg_tx_addr,
    input  logic [5:0]  cfg_word_cnt,
    input  logic [1:0]  cfg_to_sel,
    input  logic        tx_end,
    input  logic        word_vld,
    input  logic        word_cmd_sync,
    input  logic [4:0]  word_rt_addr,
    input  logic        word_enc_err,
    input  logic        word_par_err,
    input  logic        word_bit_err,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic [6:0]  err_flags
);
    phase_e          phase;
    err_t            err_q;
    err_t            err_w;
    cfg_t            cfg_q;
    logic [WC_W-1:0] rx_cnt;
    logic            listening;
    logic            arm;
    logic            tick;
    logic            expire;
    logic            last_data;

    assign listening = (phase == PH_STAT1) || (phase == PH_DATA) ||
                       (phase == PH_STAT2) || (phase == PH_TAIL);
    assign arm       = ((phase == PH_ARMED) && tx_end) || (listening && word_vld);
    assign err_w     = fold_word_flags(err_q, word_enc_err, word_par_err, word_bit_err);
    assign last_data = ((rx_cnt + WC_W'(1)) == cfg_q.wcnt);

    rt_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk (clk),
        .rst (rst),
        .clr (arm || msg_start),
        .tick(tick)
    );

    rt_reply_timer #(.CW(TMR_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .halt  (msg_start),
        .arm   (arm),
        .tick  (tick),
        .limit (timeout_us(cfg_q.to_sel)),
        .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            err_q  <= '0;
            cfg_q  <= '0;
            rx_cnt <= '0;
        end else if (msg_start) begin
            cfg_q  <= '{rt2rt: cfg_rt2rt, rt_addr: cfg_rt_addr, tx_addr: cfg_tx_addr,
                        wcnt: cfg_word_cnt, to_sel: cfg_to_sel};
            err_q  <= '0;
            rx_cnt <= '0;
            phase  <= PH_ARMED;
        end else begin
            unique case (phase)
                PH_IDLE: ;
                PH_ARMED: if (tx_end) phase <= PH_STAT1;
                PH_STAT1: begin
                    if (word_vld) begin
                        err_q <= err_w;
                        if (!word_cmd_sync)
                            err_q.sync <= 1'b1;
                        else if (word_rt_addr != (cfg_q.rt2rt ? cfg_q.tx_addr : cfg_q.rt_addr))
                            err_q.addr_mis <= 1'b1;
                        if (cfg_q.wcnt != '0) phase <= PH_DATA;
                        else                  phase <= cfg_q.rt2rt ? PH_STAT2 : PH_TAIL;
                    end else if (expire) begin
                        err_q.tmo <= 1'b1;
                        phase     <= PH_DONE;
                    end
                end
                PH_DATA: begin
                    if (word_vld) begin
                        err_q <= err_w;
                        if (word_cmd_sync) err_q.sync <= 1'b1;
                        rx_cnt <= rx_cnt + WC_W'(1);
                        if (last_data) phase <= cfg_q.rt2rt ? PH_STAT2 : PH_TAIL;
                    end else if (expire) begin
                        err_q.wcnt <= 1'b1;
                        phase      <= PH_DONE;
                    end
                end
                PH_STAT2: begin
                    if (word_vld) begin
                        err_q <= err_w;
                        if (!word_cmd_sync) begin
                            err_q.wcnt <= 1'b1;
                        end else begin
                            if (word_rt_addr != cfg_q.rt_addr) err_q.addr_mis <= 1'b1;
                            phase <= PH_TAIL;
                        end
                    end else if (expire) begin
                        err_q.tmo <= 1'b1;
                        phase     <= PH_DONE;
                    end
                end
                PH_TAIL: begin
                    if (word_vld) begin
                        err_q      <= err_w;
                        err_q.wcnt <= 1'b1;
                    end else if (expire) begin
                        phase <= PH_DONE;
                    end
                end
                PH_DONE: if (word_vld) err_q.tmo <= 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase == PH_ARMED) || listening;
    assign done      = (phase == PH_DONE);
    assign pass      = done && (err_q == '0);
    assign err_flags = err_q;
endmodule

module rt_reply_checker_sva (
    input logic       clk,
    input logic       rst,
    input logic       msg_start,
    input logic       word_vld,
    input logic       busy,
    input logic       done,
    input logic [6:0] err_flags
);
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        msg_start |=> (err_flags == 7'd0) && busy && !done);

    a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !msg_start |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    a_r9_late_word: assert property (@(posedge clk) disable iff (rst)
        (done && word_vld && !msg_start) |=> (err_flags[0] && done));

    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !msg_start) |=> done);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !msg_start) |=> $stable(err_flags));
endmodule

bind rt_reply_checker rt_reply_checker_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .msg_start(msg_start),
    .word_vld (word_vld),
    .busy     (busy),
    .done     (done),
    .err_flags(err_flags)
);

// File: tb/tb_rt_reply_checker.sv
module tb_rt_reply_checker;
    localparam int N = 4;
    localparam logic [6:0] E_TO = 7'h01, E_SY = 7'h02, E_EN = 7'h04, E_PA = 7'h08,
                           E_BI = 7'h10, E_WC = 7'h20, E_AD = 7'h40;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1, msg_start = 1'b0, cfg_rt2rt = 1'b0, tx_end = 1'b0;
    logic [4:0] cfg_rt_addr = '0, cfg_tx_addr = '0, word_rt_addr = '0;
    logic [5:0] cfg_word_cnt = '0;
    logic [1:0] cfg_to_sel = '0;
    logic       word_vld = 1'b0, word_cmd_sync = 1'b0;
    logic       word_enc_err = 1'b0, word_par_err = 1'b0, word_bit_err = 1'b0;
    logic       busy, done, pass;
    logic [6:0] err_flags;

    rt_reply_checker #(.CLKS_PER_US(N)) dut (.*);

    int         n_cmp = 0, n_bad = 0;
    logic [6:0] expq[$];
    string      tagq[$];
    logic       done_q = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected verdict when done rises
    always @(negedge clk) begin
        if (!rst && done && !done_q) begin
            if (expq.size() == 0) begin
                chk(0, "R7 unexpected verdict", err_flags, 0);
            end else begin
                automatic logic [6:0] e = expq.pop_front();
                automatic string t = tagq.pop_front();
                chk(err_flags == e, t, err_flags, e);
                chk(pass == (e == 7'd0), {t, " R7 pass"}, pass, e == 7'd0);
            end
        end
        done_q = done;
    end

    task automatic start_msg(input bit r2r, input int rt, input int tx, input int wc,
                             input int sel, input logic [6:0] exp, input string tag);
        expq.push_back(exp);
        tagq.push_back(tag);
        @(negedge clk);
        msg_start = 1'b1; cfg_rt2rt = r2r; cfg_rt_addr = 5'(rt);
        cfg_tx_addr = 5'(tx); cfg_word_cnt = 6'(wc); cfg_to_sel = 2'(sel);
        @(negedge clk);
        msg_start = 1'b0;
        chk(err_flags == 7'd0 && busy && !done, "R8 start clears", {busy, done, err_flags}, 9'h100);
    endtask

    task automatic fire();
        @(negedge clk); tx_end = 1'b1;
        @(negedge clk); tx_end = 1'b0;
    endtask

    task automatic wd(input int gap, input bit cs, input int addr, input logic [2:0] f);
        repeat (gap) @(negedge clk);
        word_vld = 1'b1; word_cmd_sync = cs; word_rt_addr = 5'(addr);
        {word_enc_err, word_par_err, word_bit_err} = f;
        @(negedge clk);
        word_vld = 1'b0; {word_enc_err, word_par_err, word_bit_err} = '0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL all: watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int c;
        repeat (5) @(negedge clk);
        chk(!busy && !done && !pass && err_flags == 0, "R11 reset state", {busy, done, pass, err_flags}, 0);
        rst = 1'b0;
        // R10: idle word ignored
        wd(2, 0, 3, 3'b111);
        repeat (2) @(negedge clk);
        chk(err_flags == 0 && !done && !busy, "R10 idle word", err_flags, 0);

        // R7: normal transmit reply
        start_msg(0, 5, 0, 3, 0, 0, "R7 normal reply");
        fire(); wd(10, 1, 5, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0);
        wait_done();
        // R9: late word after a clean verdict
        wd(3, 1, 5, 3'b111);
        @(negedge clk);
        chk(err_flags == E_TO && done && !pass, "R9 late word", {done, err_flags}, {1'b1, E_TO});

        // R10: word before tx_end ignored
        start_msg(0, 7, 0, 0, 2, 0, "R10 word before tx_end");
        wd(3, 0, 1, 3'b111);
        chk(err_flags == 0, "R10 armed word", err_flags, 0);
        fire(); wd(20, 1, 7, 0); wait_done();

        // R1: timeout timing
        start_msg(0, 4, 0, 1, 0, E_TO, "R1 no reply 18us");
        fire(); c = 0;
        while (!done) begin @(negedge clk); c++; end
        chk(c >= 71 && c <= 75, "R1 18us latency", c, 73);
        start_msg(0, 4, 0, 1, 3, E_TO, "R1 no reply 130us");
        fire(); c = 0;
        while (!done) begin @(negedge clk); c++; end
        chk(c >= 519 && c <= 523, "R1 130us latency", c, 521);
        start_msg(0, 4, 0, 0, 0, E_TO, "R1 status at 20us with 18us");
        fire(); wd(80, 1, 4, 0); wait_done();
        start_msg(0, 4, 0, 0, 1, 0, "R1 status at 20us with 22us");
        fire(); wd(80, 1, 4, 0); wait_done();

        // R2: sync checks
        start_msg(0, 5, 0, 1, 0, E_SY, "R2 status with data sync");
        fire(); wd(10, 0, 5, 0); wd(5, 0, 0, 0); wait_done();
        start_msg(0, 5, 0, 2, 0, E_SY, "R2 data with cmd sync");
        fire(); wd(10, 1, 5, 0); wd(5, 1, 0, 0); wd(5, 0, 0, 0); wait_done();

        // R3: decoder error flags
        start_msg(0, 5, 0, 2, 0, E_EN | E_PA, "R3 enc and parity");
        fire(); wd(10, 1, 5, 3'b100); wd(5, 0, 0, 3'b010); wd(5, 0, 0, 0); wait_done();
        start_msg(0, 5, 0, 2, 0, E_BI, "R3 bit count");
        fire(); wd(10, 1, 5, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 3'b001); wait_done();

        // R4: word count
        start_msg(0, 5, 0, 3, 0, E_WC, "R4 too few");
        fire(); wd(10, 1, 5, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wait_done();
        start_msg(0, 5, 0, 2, 0, E_WC, "R4 too many");
        fire(); wd(10, 1, 5, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wait_done();

        // R5: address
        start_msg(0, 5, 0, 0, 0, E_AD, "R5 address mismatch");
        fire(); wd(10, 1, 6, 0); wait_done();
        start_msg(0, 5, 0, 0, 0, E_SY, "R5 no address check on bad sync");
        fire(); wd(10, 0, 6, 0); wait_done();

        // R6: terminal-to-terminal
        start_msg(1, 9, 3, 2, 0, 0, "R6 rt2rt clean");
        fire(); wd(10, 1, 3, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wd(20, 1, 9, 0); wait_done();
        start_msg(1, 9, 3, 2, 0, E_AD, "R6 rt2rt tx status address");
        fire(); wd(10, 1, 9, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wd(20, 1, 9, 0); wait_done();
        start_msg(1, 9, 3, 1, 0, E_TO, "R6 rt2rt missing second status");
        fire(); wd(10, 1, 3, 0); wd(5, 0, 0, 0); wait_done();
        start_msg(1, 9, 3, 1, 0, E_TO, "R6 rt2rt no reply");
        fire(); wait_done();
        start_msg(1, 9, 3, 1, 0, E_WC, "R4 rt2rt extra data");
        fire(); wd(10, 1, 3, 0); wd(5, 0, 0, 0); wd(5, 0, 0, 0); wd(20, 1, 9, 0); wait_done();

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R7 all verdicts seen", expq.size(), 0);
        summary();
        $finish;
    end
endmodule